// File: doc/BRIEF.md
# Square-Wave Timer and Duty Sequencer

This block is the tone core of one pulse-wave sound channel. A CPU-side write port programs a 2-bit duty selection and an 11-bit period. The period arrives as a low byte and a 3-bit high field. A free-running divide-by-two phase lets the period timer move only on every second CPU clock. Each time the timer expires, an 8-step duty sequencer advances one position.

The sequencer walks its position downward from zero and wraps from 0 to 7. Writing the high period field sends it back to position 0 and also pulses an envelope-restart strobe. Writing the duty leaves the position where it is. The 4-bit volume, a sweep-mute flag and a length-zero flag come from neighbouring units. The sample output is the volume, forced to zero when the current duty bit is low or when either mute flag is set.

Top module: `sqr_tone_core`

## Requirements
- R1: During and after an active-low reset, the duty, the sequence position, the timer count and the divide phase are 0, `env_restart_o` is 0, and `sample_o` is 0.
- R2: The timer changes only on every second clock. On each such tick it decrements, or it reloads the programmed period t when it is at 0. One timer period is therefore t+1 ticks.
- R3: With a fixed period t, the waveform repeats every 16*(t+1) clocks. This is measured between rising edges of `sample_o` for duty 2.
- R4: The duty bit played in step k (k=0 is the step at restart) is taken from these sequences, listed in order from k=0 to k=7: duty 0 = 0,1,0,0,0,0,0,0. Duty 1 = 0,1,1,0,0,0,0,0. Duty 2 = 0,1,1,1,1,0,0,0. Duty 3 = 1,0,0,1,1,1,1,1.
- R5: The position starts at 0 and decrements by one on each timer expiry, wrapping from 0 to 7. Step k corresponds to position (8-k) mod 8.
- R6: A write to address 3 loads period bits 10:8 from data bits 2:0 and returns the position to 0. The restart takes priority over a timer expiry in the same cycle. The same write makes `env_restart_o` high for exactly the following cycle.
- R7: A write to address 0 loads the duty from data bits 7:6 and leaves the position unchanged.
- R8: A write to address 2 loads period bits 7:0 and does not disturb the running count. A write to address 1 changes nothing.
- R9: `sample_o` equals `env_vol_i` when the current duty bit is 1 and both `sweep_mute_i` and `len_zero_i` are 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register address: 0 duty, 2 period low, 3 period high |
| wdata_i | input | 8 | Write data |
| env_vol_i | input | 4 | Envelope volume |
| sweep_mute_i | input | 1 | Sweep unit silences the channel |
| len_zero_i | input | 1 | Length counter has reached zero |
| sample_o | output | 4 | Gated output sample |
| env_restart_o | output | 1 | One-cycle envelope restart strobe |

## Verification
A write to the high period field can land in the same cycle as a timer expiry. Restart and step then compete for the sequence position. The bench provokes this by tracking its own timing model and issuing the high write exactly in the cycle before a step edge. It then judges the result by the sample: with duty 3, position 0 plays volume, whereas a step to 7 plays silence. A duty write that coincides with a step is driven in the same way, and the next sample must reflect the stepped position under the new duty.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  localparam int unsigned PER_W   = 11;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned HI_W    = PER_W - DATA_W;
  localparam int unsigned SEQ_LEN = 8;
  localparam int unsigned POS_W   = $clog2(SEQ_LEN);
  localparam int unsigned DUTY_W  = 2;
  localparam int unsigned VOL_W   = 4;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned DUTY_LSB = DATA_W - DUTY_W;

  typedef enum logic [ADDR_W-1:0] {
    REG_DUTY = 2'd0,
    REG_RSVD = 2'd1,
    REG_PLO  = 2'd2,
    REG_PHI  = 2'd3
  } reg_addr_e;

  // Pattern indexed by position (position counts down from 0 after restart).
  function automatic logic [SEQ_LEN-1:0] duty_mask(input logic [DUTY_W-1:0] duty);
    logic [SEQ_LEN-1:0] m;
    case (duty)
      2'd0:    m = 8'b1000_0000;
      2'd1:    m = 8'b1100_0000;
      2'd2:    m = 8'b1111_0000;
      default: m = 8'b0011_1111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sqr_regs.sv
module sqr_regs
  import sqr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic [PER_W-1:0]  period_o,
  output logic              restart_o,
  output logic              env_restart_o
);
  logic wr_duty, wr_lo, wr_hi;
  logic [DUTY_W-1:0] duty_q;
  logic [PER_W-1:0]  period_q;
  logic              env_q;

  assign wr_duty = we_i && (addr_i == REG_DUTY);
  assign wr_lo   = we_i && (addr_i == REG_PLO);
  assign wr_hi   = we_i && (addr_i == REG_PHI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= '0;
      period_q <= '0;
      env_q    <= 1'b0;
    end else begin
      env_q <= wr_hi;
      if (wr_duty) duty_q <= wdata_i[DATA_W-1:DUTY_LSB];
      if (wr_lo)   period_q[DATA_W-1:0] <= wdata_i;
      if (wr_hi)   period_q[PER_W-1:DATA_W] <= wdata_i[HI_W-1:0];
    end
  end

  assign duty_o        = duty_q;
  assign period_o      = period_q;
  assign restart_o     = wr_hi;
  assign env_restart_o = env_q;

  p_env_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_PHI) |=> env_restart_o);
  p_env_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_PHI) |=> !env_restart_o);
  p_rsvd_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_RSVD) |=> ($stable(duty_o) && $stable(period_o)));
endmodule

// File: rtl/sqr_timer.sv
module sqr_timer
  import sqr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  output logic             step_o
);
  logic             phase_q;
  logic             tick;
  logic [PER_W-1:0] cnt_q;

  assign tick   = phase_q;
  assign step_o = tick && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (tick) begin
        if (cnt_q == '0) cnt_q <= period_i;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_alt_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);
  p_hold_off_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));
  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (cnt_q == $past(period_i)));
  p_decrement_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sqr_seq.sv
module sqr_seq
  import sqr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              restart_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              bit_o
);
  logic [POS_W-1:0]   pos_q;
  logic [SEQ_LEN-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pos_q <= '0;
    else if (restart_i) pos_q <= '0;
    else if (step_i)    pos_q <= pos_q - 1'b1;
  end

  assign mask  = duty_mask(duty_i);
  assign bit_o = mask[pos_q];

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pos_q == '0));
  p_step_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i) |=> (pos_q == $past(pos_q) - 1'b1));
  p_pos_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !restart_i) |=> $stable(pos_q));
endmodule

// File: rtl/sqr_tone_core.sv
module sqr_tone_core
  import sqr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [VOL_W-1:0]  env_vol_i,
  input  logic              sweep_mute_i,
  input  logic              len_zero_i,
  output logic [VOL_W-1:0]  sample_o,
  output logic              env_restart_o
);
  logic [DUTY_W-1:0] duty;
  logic [PER_W-1:0]  period;
  logic              restart, step, seq_bit, open;

  sqr_regs i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .duty_o(duty), .period_o(period), .restart_o(restart),
    .env_restart_o
  );

  sqr_timer i_timer (
    .clk_i, .rst_ni, .period_i(period), .step_o(step)
  );

  sqr_seq i_seq (
    .clk_i, .rst_ni, .step_i(step), .restart_i(restart),
    .duty_i(duty), .bit_o(seq_bit)
  );

  assign open     = seq_bit && !sweep_mute_i && !len_zero_i;
  assign sample_o = open ? env_vol_i : '0;

  p_mute_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_mute_i || len_zero_i) |-> (sample_o == '0));
  p_pass_vol_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o != '0) |-> (sample_o == env_vol_i));
endmodule

// File: tb/test_sqr_tone_core.sv
`timescale 1ns/1ps
module test_sqr_tone_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] vol = 4'd15;
  logic       smute = 1'b0, lzero = 1'b0;
  logic [3:0] sample;
  logic       envr;

  int tests = 0, fails = 0;
  int cyc_n = 0, last_rise = 0, rise_gap = 0;
  logic prev_on = 1'b0, cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  sqr_tone_core i_sqr_tone_core (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .env_vol_i(vol), .sweep_mute_i(smute), .len_zero_i(lzero),
    .sample_o(sample), .env_restart_o(envr)
  );

  // Reference model from the requirements
  logic        m_phase, m_env;
  logic [10:0] m_cnt, m_per;
  logic [2:0]  m_pos;
  logic [1:0]  m_duty;
  wire         m_step = m_phase && (m_cnt == 11'd0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_env <= 0; m_cnt <= 0; m_per <= 0; m_pos <= 0; m_duty <= 0;
    end else begin
      m_phase <= ~m_phase;
      m_env   <= we && addr == 2'd3;
      if (m_phase) m_cnt <= (m_cnt == 0) ? m_per : m_cnt - 11'd1;
      if (we && addr == 2'd3) m_pos <= 3'd0;
      else if (m_step)        m_pos <= m_pos - 3'd1;
      if (we && addr == 2'd0) m_duty <= wdata[7:6];
      if (we && addr == 2'd2) m_per[7:0] <= wdata;
      if (we && addr == 2'd3) m_per[10:8] <= wdata[2:0];
    end
  end

  // Played sequences, MSB = step 0 after restart
  function automatic logic play_bit(input logic [1:0] d, input logic [2:0] pos);
    logic [7:0] s;
    int k;
    case (d)
      2'd0: s = 8'b0100_0000;
      2'd1: s = 8'b0110_0000;
      2'd2: s = 8'b0111_1000;
      default: s = 8'b1001_1111;
    endcase
    k = (8 - int'(pos)) % 8;
    return s[7-k];
  endfunction

  function automatic logic [3:0] exp_sample();
    return (play_bit(m_duty, m_pos) && !smute && !lzero) ? vol : 4'd0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  // Advance one clock; compare at the falling edge, then leave inputs idle
  task automatic cyc();
    @(negedge clk);
    cyc_n++;
    if (cmp_en) begin
      check("R4 sample", sample, exp_sample());
      check("R6 env strobe", envr, m_env);
    end
    if (sample != 0 && !prev_on) begin
      rise_gap = cyc_n - last_rise;
      last_rise = cyc_n;
    end
    prev_on = (sample != 0);
    we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
  endtask

  task automatic set_period(input int t);
    we = 1'b1; addr = 2'd2; wdata = t[7:0];
    cyc();
    we = 1'b1; addr = 2'd3; wdata = {5'd0, t[10:8]};
    cyc();
  endtask

  task automatic measure(input int t);
    wr(2'd0, 8'h80);
    set_period(t);
    repeat (40 * (t + 1)) cyc();
    check($sformatf("R3 period t=%0d", t), rise_gap, 16 * (t + 1));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    check("R1 reset sample", sample, 0);
    check("R1 reset strobe", envr, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    cyc();
    check("R1 sample after reset", sample, 0);

    // Period and all duties at several periods
    measure(0);
    measure(3);
    measure(17);
    measure(200);
    for (int d = 0; d < 4; d++) begin
      wr(2'd0, 8'(d << 6));
      set_period(2);
      repeat (60) cyc();
    end

    // R7: duty change mid-waveform keeps position
    wr(2'd0, 8'h80);
    set_period(1);
    while (m_pos != 3'd5) cyc();
    wr(2'd0, 8'h00);
    check("R7 duty0 at pos5", sample, 0);
    wr(2'd0, 8'hC0);
    check("R7 duty3 at pos5", sample, 15);
    check("R7 position kept", m_pos, 5);

    // R6: restart coincident with a step
    vol = 4'd9;
    for (int n = 0; n < 3; n++) begin
      while (!(m_phase && m_cnt == 0 && m_pos != 3'd1)) cyc();
      wr(2'd3, 8'h00);
      check("R6 restart beats step", sample, 9);
      check("R6 env strobe after write", envr, 1);
      cyc();
      check("R6 env strobe one cycle", envr, 0);
    end

    // R7: duty write coincident with a step
    while (!(m_phase && m_cnt == 0 && m_pos == 3'd0)) cyc();
    wr(2'd0, 8'h80);
    check("R7 duty with step (pos7, duty2)", sample, 9);

    // R8: low write leaves running count; reserved address ignored
    set_period(40);
    repeat (7) cyc();
    wr(2'd2, 8'd3);
    wr(2'd1, 8'hFF);
    repeat (200) cyc();

    // R9: gating
    wr(2'd0, 8'hC0);
    wr(2'd3, 8'h00);
    check("R9 open", sample, 9);
    smute = 1'b1; cyc();
    check("R9 sweep mute", sample, 0);
    smute = 1'b0; lzero = 1'b1; cyc();
    check("R9 length zero", sample, 0);
    lzero = 1'b0;

    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      vol   = 4'($urandom_range(0, 15));
      smute = ($urandom_range(0, 7) == 0);
      lzero = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) begin
        we = 1'b1;
        addr = 2'($urandom_range(0, 3));
        wdata = 8'($urandom_range(0, 255));
        if (addr == 2'd3) wdata[2:0] = 3'd0;
        if (addr == 2'd2) wdata = 8'($urandom_range(0, 12));
      end
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule